// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of taking an exception in a pipelined CPU's system coprocessor. A request carries an exception class, a load/store flag, the number of the offending coprocessor, the faulting virtual address and translation fields, and the program counter and next program counter of the faulting instruction. On the clock edge that accepts the request, the block updates the status, cause, exception-PC, bad-address, translation-entry, context and shadow-register-set state. In the next cycle it presents a redirect: the handler address, followed by the next two sequential fetch addresses.

The handler address depends on the class of the exception and on three mode bits. These are the exception-level bit held inside the block, read before the entry sets it, and two inputs: the bootstrap-vector select and the dedicated-interrupt-vector select. The exception base address and the shadow set to enter come from the surrounding coprocessor. A reset-entry class sends fetch to the boot vector and enables coprocessor 1. It leaves the exception PC and the cause fields alone.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Every accepted exception entry (every known class except reset entry) sets the exception-level bit `st_exl` to 1, whether or not it was already 1.
- R2: On an entry where `st_exl` and `cfg_bev` are both 0 before the edge, the previous-set field takes the old current-set value and the current-set field takes `cfg_ess`. On any other entry, both fields keep their values.
- R3: When `cur_pc + 4 != cur_npc`, the instruction sits in a delay slot: `epc` becomes `cur_pc - 4` and `cause_bd` becomes 1. Otherwise `epc` becomes `cur_pc` and `cause_bd` becomes 0.
- R4: `cause_code` is written from the class codes on `req_class`, with `req_store` selecting between load and store variants. The codes are: 0 interrupt→0x0, 1 translation-modified→0x1, 2 refill and 3 invalid→0x2 (load) or 0x3 (store), 4 address error→0x4 (load) or 0x5 (store), 5 syscall→0x8, 6 breakpoint→0x9, 7 reserved instruction→0xA, 8 coprocessor unusable→0xB, 9 overflow→0xC, 10 trap→0xD.
- R5: A coprocessor-unusable entry writes `req_cop_id` into `cause_ce`. Every other entry clears `cause_ce`.
- R6: Classes with no special vector redirect to `cfg_ebase + 0x180`.
- R7: A refill entry taken while `st_exl` was 0 redirects to `cfg_ebase + 0x000`. One taken while `st_exl` was 1 redirects to `cfg_ebase + 0x180`.
- R8: An interrupt entry redirects to `cfg_ebase + 0x200` when `cfg_iv` is 1, and to `cfg_ebase + 0x180` otherwise.
- R9: An overflow entry with `cfg_bev` = 1 redirects to 0xBFC00200. With `cfg_bev` = 0 it redirects to `cfg_ebase + 0x180`.
- R10: One cycle after an accepted request, `redir_valid` is 1, with `redir_npc = redir_pc + 4` and `redir_nnpc = redir_pc + 8`. Without a request, `redir_valid` is 0.
- R11: Refill, invalid and modified entries load `badvaddr`, the translation-entry ASID/VPN2/VPN2X fields and the context BadVPN2 field from the request. Address-error entries load only `badvaddr`. No other class touches these fields.
- R12: Reset entry (class 11) redirects to 0xBFC00000 and sets `st_cu1`. It leaves `epc`, the cause fields, `st_exl` and the shadow-set fields unchanged.
- R13: A request with a class code of 12 to 15 is ignored: no redirect and no state change.
- R14: Synchronous reset clears every register output and `redir_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception request this cycle |
| req_class | input | 4 | Exception class code |
| req_store | input | 1 | Fault was on a store |
| req_cop_id | input | 2 | Offending coprocessor number |
| req_vaddr | input | 32 | Faulting virtual address |
| req_asid | input | 8 | ASID for translation-entry register |
| req_vpn2 | input | 19 | VPN2 for translation-entry register |
| req_vpn2x | input | 2 | VPN2 extension for translation-entry register |
| req_ctx_vpn2 | input | 19 | BadVPN2 for context register |
| cur_pc | input | 32 | PC of faulting instruction |
| cur_npc | input | 32 | Next PC at time of fault |
| cfg_ebase | input | 32 | Exception base address |
| cfg_bev | input | 1 | Bootstrap vector select |
| cfg_iv | input | 1 | Dedicated interrupt vector select |
| cfg_ess | input | 4 | Shadow set to use for exceptions |
| st_exl | output | 1 | Exception-level bit |
| st_cu1 | output | 1 | Coprocessor 1 usable |
| srs_css | output | 4 | Current shadow set |
| srs_pss | output | 4 | Previous shadow set |
| cause_code | output | 5 | Exception code |
| cause_bd | output | 1 | Delay-slot flag |
| cause_ce | output | 2 | Coprocessor number field |
| epc | output | 32 | Exception PC |
| badvaddr | output | 32 | Bad virtual address |
| entryhi_asid | output | 8 | Translation-entry ASID |
| entryhi_vpn2 | output | 19 | Translation-entry VPN2 |
| entryhi_vpn2x | output | 2 | Translation-entry VPN2X |
| ctx_badvpn2 | output | 19 | Context BadVPN2 |
| redir_valid | output | 1 | Redirect present |
| redir_pc | output | 32 | Handler PC |
| redir_npc | output | 32 | Handler PC + 4 |
| redir_nnpc | output | 32 | Handler PC + 8 |

## Verification
Every class is driven from a fresh reset with load and store variants, so that each code is told apart from the others. Refill is taken both as a first and as a nested entry, so the exception-level bit is read before it is set. Overflow and interrupt are each taken with their mode bit on and then off. Sequential and non-sequential next-PC values separate the delay-slot path from the plain path. A nested entry and an entry with the bootstrap bit set show the shadow-set fields holding. A translation fault followed by an address error, and reset entry after a syscall, show which fields each class may overwrite. Class codes 12 to 15 confirm that undefined requests change nothing.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam int CODE_W = 5;
    localparam int CE_W   = 2;
    localparam int CLS_W  = 4;

    typedef enum logic [CLS_W-1:0] {
        EXC_INT     = 4'd0,
        EXC_TMOD    = 4'd1,
        EXC_TREFILL = 4'd2,
        EXC_TINV    = 4'd3,
        EXC_ADDR    = 4'd4,
        EXC_SYS     = 4'd5,
        EXC_BRK     = 4'd6,
        EXC_RESV    = 4'd7,
        EXC_COPU    = 4'd8,
        EXC_OVF     = 4'd9,
        EXC_TRAP    = 4'd10,
        EXC_RESET   = 4'd11
    } exc_class_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              bd;
        logic [CE_W-1:0]   ce;
    } cause_t;

    function automatic logic class_known(input logic [CLS_W-1:0] c);
        return c <= CLS_W'(EXC_RESET);
    endfunction

    function automatic logic writes_xlat(input exc_class_e c);
        return (c == EXC_TMOD) || (c == EXC_TREFILL) || (c == EXC_TINV);
    endfunction

    function automatic logic [CODE_W-1:0] exc_code(input exc_class_e c, input logic st);
        case (c)
            EXC_TMOD:             return 5'h01;
            EXC_TREFILL, EXC_TINV: return st ? 5'h03 : 5'h02;
            EXC_ADDR:             return st ? 5'h05 : 5'h04;
            EXC_SYS:              return 5'h08;
            EXC_BRK:              return 5'h09;
            EXC_RESV:             return 5'h0A;
            EXC_COPU:             return 5'h0B;
            EXC_OVF:              return 5'h0C;
            EXC_TRAP:             return 5'h0D;
            default:              return 5'h00;
        endcase
    endfunction

endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter logic [XLEN-1:0] RESET_VEC   = 32'hBFC0_0000,
    parameter logic [XLEN-1:0] BEV_OVF_VEC = 32'hBFC0_0200,
    parameter logic [XLEN-1:0] GEN_OFF     = 32'h180,
    parameter logic [XLEN-1:0] IRQ_OFF     = 32'h200,
    parameter logic [XLEN-1:0] REFILL_OFF  = 32'h000
) (
    input  exc_class_e      cls,
    input  logic            exl_before,
    input  logic            bev,
    input  logic            iv,
    input  logic [XLEN-1:0] ebase,
    output logic [XLEN-1:0] handler
);
    always_comb begin
        handler = ebase + GEN_OFF;
        case (cls)
            EXC_RESET:   handler = RESET_VEC;
            EXC_TREFILL: if (!exl_before) handler = ebase + REFILL_OFF;
            EXC_INT:     if (iv) handler = ebase + IRQ_OFF;
            EXC_OVF:     if (bev) handler = BEV_OVF_VEC;
            default:     handler = ebase + GEN_OFF;
        endcase
    end
endmodule

// File: rtl/exc_epc_calc.sv
module exc_epc_calc #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] epc_new,
    output logic            in_slot
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        in_slot = (pc + STEP) != npc;
        epc_new = in_slot ? (pc - STEP) : pc;
    end
endmodule

// File: rtl/exc_csr_bank.sv
module exc_csr_bank
    import exc_entry_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ASID_W  = 8,
    parameter int VPN2_W  = 19,
    parameter int VPN2X_W = 2,
    parameter int SRS_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               take_exc,
    input  logic               take_reset,
    input  exc_class_e         cls,
    input  logic               store,
    input  logic [CE_W-1:0]    cop_id,
    input  logic [XLEN-1:0]    vaddr,
    input  logic [ASID_W-1:0]  asid,
    input  logic [VPN2_W-1:0]  vpn2,
    input  logic [VPN2X_W-1:0] vpn2x,
    input  logic [VPN2_W-1:0]  ctx_vpn2,
    input  logic [XLEN-1:0]    epc_new,
    input  logic               bd_new,
    input  logic               bev,
    input  logic [SRS_W-1:0]   ess,
    output logic               exl,
    output logic               cu1,
    output logic [SRS_W-1:0]   css,
    output logic [SRS_W-1:0]   pss,
    output cause_t             cause,
    output logic [XLEN-1:0]    epc,
    output logic [XLEN-1:0]    badvaddr,
    output logic [ASID_W-1:0]  eh_asid,
    output logic [VPN2_W-1:0]  eh_vpn2,
    output logic [VPN2X_W-1:0] eh_vpn2x,
    output logic [VPN2_W-1:0]  ctx_badvpn2
);
    always_ff @(posedge clk) begin
        if (rst) begin
            exl         <= 1'b0;
            cu1         <= 1'b0;
            css         <= '0;
            pss         <= '0;
            cause       <= '0;
            epc         <= '0;
            badvaddr    <= '0;
            eh_asid     <= '0;
            eh_vpn2     <= '0;
            eh_vpn2x    <= '0;
            ctx_badvpn2 <= '0;
        end else begin
            if (take_exc) begin
                exl <= 1'b1;
                if (!exl && !bev) begin
                    pss <= css;
                    css <= ess;
                end
                epc        <= epc_new;
                cause.bd   <= bd_new;
                cause.code <= exc_code(cls, store);
                cause.ce   <= (cls == EXC_COPU) ? cop_id : '0;
                if (writes_xlat(cls) || cls == EXC_ADDR)
                    badvaddr <= vaddr;
                if (writes_xlat(cls)) begin
                    eh_asid     <= asid;
                    eh_vpn2     <= vpn2;
                    eh_vpn2x    <= vpn2x;
                    ctx_badvpn2 <= ctx_vpn2;
                end
            end
            if (take_reset)
                cu1 <= 1'b1;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int ASID_W     = 8,
    parameter int VPN2_W     = 19,
    parameter int VPN2X_W    = 2,
    parameter int SRS_W      = 4,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CLS_W-1:0]   req_class,
    input  logic               req_store,
    input  logic [CE_W-1:0]    req_cop_id,
    input  logic [XLEN-1:0]    req_vaddr,
    input  logic [ASID_W-1:0]  req_asid,
    input  logic [VPN2_W-1:0]  req_vpn2,
    input  logic [VPN2X_W-1:0] req_vpn2x,
    input  logic [VPN2_W-1:0]  req_ctx_vpn2,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    cur_npc,
    input  logic [XLEN-1:0]    cfg_ebase,
    input  logic               cfg_bev,
    input  logic               cfg_iv,
    input  logic [SRS_W-1:0]   cfg_ess,
    output logic               st_exl,
    output logic               st_cu1,
    output logic [SRS_W-1:0]   srs_css,
    output logic [SRS_W-1:0]   srs_pss,
    output logic [CODE_W-1:0]  cause_code,
    output logic               cause_bd,
    output logic [CE_W-1:0]    cause_ce,
    output logic [XLEN-1:0]    epc,
    output logic [XLEN-1:0]    badvaddr,
    output logic [ASID_W-1:0]  entryhi_asid,
    output logic [VPN2_W-1:0]  entryhi_vpn2,
    output logic [VPN2X_W-1:0] entryhi_vpn2x,
    output logic [VPN2_W-1:0]  ctx_badvpn2,
    output logic               redir_valid,
    output logic [XLEN-1:0]    redir_pc,
    output logic [XLEN-1:0]    redir_npc,
    output logic [XLEN-1:0]    redir_nnpc
);
    localparam int REDIR_N = 3;

    exc_class_e      cls;
    logic            known, take_exc, take_reset, take_any;
    logic [XLEN-1:0] handler, epc_new;
    logic            in_slot;
    cause_t          cause_q;
    logic [XLEN-1:0] seq   [REDIR_N];
    logic [XLEN-1:0] seq_q [REDIR_N];

    assign cls        = exc_class_e'(req_class);
    assign known      = class_known(req_class);
    assign take_any   = req_valid && known;
    assign take_reset = take_any && (cls == EXC_RESET);
    assign take_exc   = take_any && (cls != EXC_RESET);

    exc_vector_sel #(.XLEN(XLEN)) u_vec (
        .cls        (cls),
        .exl_before (st_exl),
        .bev        (cfg_bev),
        .iv         (cfg_iv),
        .ebase      (cfg_ebase),
        .handler    (handler)
    );

    exc_epc_calc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_epc (
        .pc      (cur_pc),
        .npc     (cur_npc),
        .epc_new (epc_new),
        .in_slot (in_slot)
    );

    exc_csr_bank #(
        .XLEN(XLEN), .ASID_W(ASID_W), .VPN2_W(VPN2_W),
        .VPN2X_W(VPN2X_W), .SRS_W(SRS_W)
    ) u_csr (
        .clk         (clk),
        .rst         (rst),
        .take_exc    (take_exc),
        .take_reset  (take_reset),
        .cls         (cls),
        .store       (req_store),
        .cop_id      (req_cop_id),
        .vaddr       (req_vaddr),
        .asid        (req_asid),
        .vpn2        (req_vpn2),
        .vpn2x       (req_vpn2x),
        .ctx_vpn2    (req_ctx_vpn2),
        .epc_new     (epc_new),
        .bd_new      (in_slot),
        .bev         (cfg_bev),
        .ess         (cfg_ess),
        .exl         (st_exl),
        .cu1         (st_cu1),
        .css         (srs_css),
        .pss         (srs_pss),
        .cause       (cause_q),
        .epc         (epc),
        .badvaddr    (badvaddr),
        .eh_asid     (entryhi_asid),
        .eh_vpn2     (entryhi_vpn2),
        .eh_vpn2x    (entryhi_vpn2x),
        .ctx_badvpn2 (ctx_badvpn2)
    );

    assign cause_code = cause_q.code;
    assign cause_bd   = cause_q.bd;
    assign cause_ce   = cause_q.ce;

    // Sequential fetch addresses following the handler entry point
    for (genvar gi = 0; gi < REDIR_N; gi++) begin : g_seq
        assign seq[gi] = handler + XLEN'(gi * INSN_BYTES);
        always_ff @(posedge clk) begin
            if (rst)           seq_q[gi] <= '0;
            else if (take_any) seq_q[gi] <= seq[gi];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) redir_valid <= 1'b0;
        else     redir_valid <= take_any;
    end

    assign redir_pc   = seq_q[0];
    assign redir_npc  = seq_q[1];
    assign redir_nnpc = seq_q[2];
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
    parameter int XLEN  = 32,
    parameter int SRS_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [3:0]       req_class,
    input logic [XLEN-1:0]  cur_pc,
    input logic [XLEN-1:0]  cur_npc,
    input logic             cfg_bev,
    input logic [SRS_W-1:0] cfg_ess,
    input logic             st_exl,
    input logic [SRS_W-1:0] srs_css,
    input logic [SRS_W-1:0] srs_pss,
    input logic             cause_bd,
    input logic [XLEN-1:0]  epc,
    input logic             redir_valid,
    input logic [XLEN-1:0]  redir_pc,
    input logic [XLEN-1:0]  redir_npc,
    input logic [XLEN-1:0]  redir_nnpc
);
    logic entry;
    assign entry = req_valid && (req_class <= 4'd10);

    AST_EXL_SET: assert property (@(posedge clk) disable iff (rst)
        entry |=> st_exl);  // R1

    AST_SRS_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (entry && !st_exl && !cfg_bev) |=>
            (srs_pss == $past(srs_css) && srs_css == $past(cfg_ess)));  // R2

    AST_SRS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (entry && (st_exl || cfg_bev)) |=> ($stable(srs_css) && $stable(srs_pss)));  // R2

    AST_SLOT_EPC: assert property (@(posedge clk) disable iff (rst)
        (entry && (cur_pc + XLEN'(4) != cur_npc)) |=>
            (cause_bd && epc == $past(cur_pc) - XLEN'(4)));  // R3

    AST_REDIR_SEQ: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> (redir_npc == redir_pc + XLEN'(4) &&
                         redir_nnpc == redir_pc + XLEN'(8)));  // R10

    AST_NO_IDLE_REDIR: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !redir_valid);  // R10

    AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_class > 4'd11) |=> (!redir_valid && $stable(epc)));  // R13
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN), .SRS_W(SRS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_class   (req_class),
    .cur_pc      (cur_pc),
    .cur_npc     (cur_npc),
    .cfg_bev     (cfg_bev),
    .cfg_ess     (cfg_ess),
    .st_exl      (st_exl),
    .srs_css     (srs_css),
    .srs_pss     (srs_pss),
    .cause_bd    (cause_bd),
    .epc         (epc),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .redir_npc   (redir_npc),
    .redir_nnpc  (redir_nnpc)
);

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_class = '0;
    logic        req_store = 1'b0;
    logic [1:0]  req_cop_id = '0;
    logic [31:0] req_vaddr = '0;
    logic [7:0]  req_asid = '0;
    logic [18:0] req_vpn2 = '0;
    logic [1:0]  req_vpn2x = '0;
    logic [18:0] req_ctx_vpn2 = '0;
    logic [31:0] cur_pc = '0;
    logic [31:0] cur_npc = '0;
    logic [31:0] cfg_ebase = 32'h8000_0000;
    logic        cfg_bev = 1'b0;
    logic        cfg_iv = 1'b0;
    logic [3:0]  cfg_ess = 4'h3;

    logic        st_exl, st_cu1, cause_bd, redir_valid;
    logic [3:0]  srs_css, srs_pss;
    logic [4:0]  cause_code;
    logic [1:0]  cause_ce, entryhi_vpn2x;
    logic [31:0] epc, badvaddr, redir_pc, redir_npc, redir_nnpc;
    logic [7:0]  entryhi_asid;
    logic [18:0] entryhi_vpn2, ctx_badvpn2;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    localparam logic [31:0] EB = 32'h8000_0000;
    localparam logic [31:0] PC = 32'h8000_1000;

    always #5 clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply_rst();
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic fire(input logic [3:0] c, input logic st, input logic [1:0] cop,
                        input logic [31:0] pc, input logic [31:0] npc);
        @(negedge clk);
        req_class = c; req_store = st; req_cop_id = cop;
        cur_pc = pc; cur_npc = npc; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [4:0] want_code(input int c, input logic st);
        case (c)
            0: return 5'h0;   1: return 5'h1;
            2, 3: return st ? 5'h3 : 5'h2;
            4: return st ? 5'h5 : 5'h4;
            5: return 5'h8;   6: return 5'h9;   7: return 5'hA;
            8: return 5'hB;   9: return 5'hC;   10: return 5'hD;
            default: return 5'h0;
        endcase
    endfunction

    task automatic t_reset_state();
        apply_rst();
        chk("R14 exl", 32'(st_exl), 0);
        chk("R14 redir_valid", 32'(redir_valid), 0);
        chk("R14 epc", epc, 0);
        chk("R14 cause_code", 32'(cause_code), 0);
        chk("R14 css", 32'(srs_css), 0);
        chk("R14 cu1", 32'(st_cu1), 0);
        chk("R10 idle no redirect", 32'(redir_valid), 0);
    endtask

    task automatic t_codes();
        for (int c = 0; c <= 10; c++) begin
            for (int s = 0; s < 2; s++) begin
                apply_rst();
                fire(4'(c), 1'(s), 2'd0, PC, PC + 4);
                chk($sformatf("R4 code class %0d store %0d", c, s), 32'(cause_code), 32'(want_code(c, 1'(s))));
                chk($sformatf("R1 exl class %0d", c), 32'(st_exl), 1);
                chk($sformatf("R10 valid class %0d", c), 32'(redir_valid), 1);
            end
        end
    endtask

    task automatic t_srs();
        apply_rst();
        cfg_ess = 4'h3;
        fire(4'd5, 0, 0, PC, PC + 4);
        chk("R2 css switched", 32'(srs_css), 3);
        chk("R2 pss from old css", 32'(srs_pss), 0);
        cfg_ess = 4'h5;
        fire(4'd6, 0, 0, PC, PC + 4);
        chk("R2 css held on nested", 32'(srs_css), 3);
        chk("R1 exl stays 1", 32'(st_exl), 1);
        apply_rst();
        cfg_bev = 1'b1;
        fire(4'd5, 0, 0, PC, PC + 4);
        chk("R2 css held with bev", 32'(srs_css), 0);
        cfg_bev = 1'b0; cfg_ess = 4'h3;
    endtask

    task automatic t_epc();
        apply_rst();
        fire(4'd5, 0, 0, PC, PC + 4);
        chk("R3 epc plain", epc, PC);
        chk("R3 bd plain", 32'(cause_bd), 0);
        fire(4'd5, 0, 0, PC, 32'h8000_2000);
        chk("R3 epc slot", epc, PC - 4);
        chk("R3 bd slot", 32'(cause_bd), 1);
    endtask

    task automatic t_ce();
        apply_rst();
        fire(4'd8, 0, 2'd2, PC, PC + 4);
        chk("R5 ce copu", 32'(cause_ce), 2);
        fire(4'd6, 0, 2'd3, PC, PC + 4);
        chk("R5 ce cleared", 32'(cause_ce), 0);
    endtask

    task automatic t_vectors();
        apply_rst();
        fire(4'd5, 0, 0, PC, PC + 4);
        chk("R6 general", redir_pc, EB + 32'h180);
        chk("R10 npc", redir_npc, EB + 32'h184);
        chk("R10 nnpc", redir_nnpc, EB + 32'h188);
        apply_rst();
        fire(4'd2, 0, 0, PC, PC + 4);
        chk("R7 refill exl0", redir_pc, EB);
        fire(4'd2, 0, 0, PC, PC + 4);
        chk("R7 refill exl1", redir_pc, EB + 32'h180);
        apply_rst();
        cfg_iv = 1'b1;
        fire(4'd0, 0, 0, PC, PC + 4);
        chk("R8 int iv1", redir_pc, EB + 32'h200);
        cfg_iv = 1'b0;
        fire(4'd0, 0, 0, PC, PC + 4);
        chk("R8 int iv0", redir_pc, EB + 32'h180);
        cfg_bev = 1'b1;
        fire(4'd9, 0, 0, PC, PC + 4);
        chk("R9 ovf bev1", redir_pc, 32'hBFC0_0200);
        chk("R9 ovf bev1 nnpc", redir_nnpc, 32'hBFC0_0208);
        cfg_bev = 1'b0;
        fire(4'd9, 0, 0, PC, PC + 4);
        chk("R9 ovf bev0", redir_pc, EB + 32'h180);
    endtask

    task automatic t_xlat();
        apply_rst();
        req_vaddr = 32'h1234_5678; req_asid = 8'h5A; req_vpn2 = 19'h2_468A;
        req_vpn2x = 2'd3; req_ctx_vpn2 = 19'h1_1111;
        fire(4'd3, 1, 0, PC, PC + 4);
        chk("R11 badvaddr tlb", badvaddr, 32'h1234_5678);
        chk("R11 asid", 32'(entryhi_asid), 32'h5A);
        chk("R11 vpn2", 32'(entryhi_vpn2), 32'h2_468A);
        chk("R11 vpn2x", 32'(entryhi_vpn2x), 3);
        chk("R11 ctx", 32'(ctx_badvpn2), 32'h1_1111);
        req_vaddr = 32'h0BAD_0004; req_asid = 8'h11; req_vpn2 = 19'h0; req_ctx_vpn2 = 19'h0;
        fire(4'd4, 0, 0, PC, PC + 4);
        chk("R11 badvaddr addr", badvaddr, 32'h0BAD_0004);
        chk("R11 asid kept", 32'(entryhi_asid), 32'h5A);
        chk("R11 ctx kept", 32'(ctx_badvpn2), 32'h1_1111);
        req_vaddr = 32'hFFFF_0000;
        fire(4'd5, 0, 0, PC, PC + 4);
        chk("R11 syscall no badvaddr", badvaddr, 32'h0BAD_0004);
    endtask

    task automatic t_reset_entry();
        apply_rst();
        fire(4'd5, 0, 0, PC, PC + 4);
        fire(4'd11, 0, 0, 32'h8000_3000, 32'h8000_5000);
        chk("R12 pc", redir_pc, 32'hBFC0_0000);
        chk("R12 npc", redir_npc, 32'hBFC0_0004);
        chk("R12 nnpc", redir_nnpc, 32'hBFC0_0008);
        chk("R12 cu1", 32'(st_cu1), 1);
        chk("R12 epc kept", epc, PC);
        chk("R12 code kept", 32'(cause_code), 8);
        chk("R12 bd kept", 32'(cause_bd), 0);
    endtask

    task automatic t_ignored();
        apply_rst();
        fire(4'd5, 0, 0, PC, PC + 4);
        for (int c = 12; c < 16; c++) begin
            fire(4'(c), 1, 2'd1, 32'h8000_7000, 32'h8000_9000);
            chk($sformatf("R13 no redirect class %0d", c), 32'(redir_valid), 0);
            chk($sformatf("R13 epc kept class %0d", c), epc, PC);
            chk($sformatf("R13 code kept class %0d", c), 32'(cause_code), 8);
        end
    endtask

    initial begin
        t_reset_state();
        t_codes();
        t_srs();
        t_epc();
        t_ce();
        t_vectors();
        t_xlat();
        t_reset_entry();
        t_ignored();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule